// File: doc/BRIEF.md
# Two's-Complement Add/Subtract Unit

This block is a purely combinational N-bit arithmetic stage, four bits wide by default. It has two operands and a one-bit operation select. When the select is low the unit adds the operands. When it is high the unit computes the first operand minus the second. It does this by flipping every bit of the second operand and feeding the select into the carry input of the lowest stage, which supplies the "+1" of the two's complement. The stages are full-adder cells joined in a ripple chain.

Three further outputs come with the result. The first is the top-stage carry corrected by the operation select, so that in subtract mode it reads as an unsigned borrow. The second is a signed overflow flag. The third is a display form of the result: negative values are turned into sign-magnitude form by decrementing the result and inverting every bit below the sign bit. Non-negative values pass through unchanged. Read as signed, the most negative value (for example -8 at four bits, or -128 at eight bits, where the range is -128..127 signed and 0..255 unsigned) has no positive counterpart. Its display form therefore comes out as a set sign bit over a zero magnitude.

Top module: `addsub_unit`

## Requirements
- R1: With `op_sub_i` = 0, `res_o` equals (`opa_i` + `opb_i`) mod 2^W.
- R2: With `op_sub_i` = 1, `res_o` equals (`opa_i` - `opb_i`) mod 2^W.
- R3: With `op_sub_i` = 0, `cflag_o` is 1 exactly when the unsigned sum `opa_i` + `opb_i` is at least 2^W.
- R4: With `op_sub_i` = 1, `cflag_o` is 1 exactly when `opa_i` < `opb_i` as unsigned numbers (borrow).
- R5: `ovf_o` is 1 exactly when the true signed result (both operands read as W-bit two's complement) lies outside -2^(W-1) .. 2^(W-1)-1.
- R6: When bit W-1 of `res_o` is 0, `disp_o` equals `res_o`.
- R7: When bit W-1 of `res_o` is 1, bit W-1 of `disp_o` is 1 and bits W-2..0 of `disp_o` hold the low W-1 bits of the magnitude 2^W - `res_o`.
- R8: When `res_o` is the most negative value (only bit W-1 set), `disp_o` also has only bit W-1 set, that is a zero magnitude with the negative flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | W | First operand (minuend in subtract mode) |
| opb_i | input | W | Second operand (subtrahend in subtract mode) |
| op_sub_i | input | 1 | Operation select: 0 add, 1 subtract |
| res_o | output | W | Result modulo 2^W |
| cflag_o | output | 1 | Carry in add mode, borrow in subtract mode |
| ovf_o | output | 1 | Signed overflow |
| disp_o | output | W | Sign-magnitude display form of the result |

## Verification
Immediate assertions in the RTL check the arithmetic on every input change. Each cell's two-bit total must match its inputs. The whole chain's W+1-bit total must match the operands after conditional inversion. At the top, the borrow must agree with an unsigned compare, the overflow flag with the operand and result signs, and both display branches with the result. The bench is needed for what a local relation cannot show: that each mode, swept over all operand pairs at the default width and over random pairs, yields the right arithmetic value. It also shows the named corner values, in particular the most negative result and its "negative zero" display form.

// File: rtl/addsub_pkg.sv
package addsub_pkg;

  typedef enum logic {
    MODE_ADD = 1'b0,
    MODE_SUB = 1'b1
  } mode_e;

  function automatic logic fa_sum(input logic x, input logic y, input logic c);
    return x ^ y ^ c;
  endfunction

  function automatic logic fa_carry(input logic x, input logic y, input logic c);
    return (x & y) | (c & (x ^ y));
  endfunction

  function automatic logic cond_flip(input logic bit_in, input logic flip);
    return bit_in ^ flip;
  endfunction

endpackage

// File: rtl/addsub_cell.sv
module addsub_cell
  import addsub_pkg::*;
(
  input  logic x_i,
  input  logic y_i,
  input  logic c_i,
  output logic s_o,
  output logic c_o
);

  assign s_o = fa_sum(x_i, y_i, c_i);
  assign c_o = fa_carry(x_i, y_i, c_i);

  always_comb begin
    AST_CELL_TOTAL: assert ({c_o, s_o} == (2'(x_i) + 2'(y_i) + 2'(c_i))); // R1
  end

endmodule

// File: rtl/addsub_chain.sv
module addsub_chain
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         mode_i,
  output logic [W-1:0] s_o,
  output logic         cout_o,
  output logic         cin_top_o
);

  localparam int CW = W + 1;

  logic [W-1:0] b_eff;
  logic [W:0]   carry;
  logic [CW-1:0] ref_total;

  assign carry[0] = mode_i;

  for (genvar i = 0; i < W; i++) begin : g_stage
    assign b_eff[i] = cond_flip(b_i[i], mode_i);
    addsub_cell u_cell (
      .x_i (a_i[i]),
      .y_i (b_eff[i]),
      .c_i (carry[i]),
      .s_o (s_o[i]),
      .c_o (carry[i+1])
    );
  end

  assign cout_o    = carry[W];
  assign cin_top_o = carry[W-1];

  always_comb begin
    ref_total = {1'b0, a_i} + {1'b0, b_eff} + CW'(mode_i);
    AST_CHAIN_TOTAL: assert ({cout_o, s_o} == ref_total); // R2
  end

endmodule

// File: rtl/addsub_signmag.sv
module addsub_signmag #(
  parameter int W = 4
) (
  input  logic [W-1:0] r_i,
  output logic [W-1:0] d_o
);

  localparam int MSB = W - 1;

  logic [W-1:0] dec;
  logic [W:0]   brw;
  logic         is_neg;
  logic [W-1:0] neg_r;

  assign brw[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_dec
    assign dec[i]   = r_i[i] ^ brw[i];
    assign brw[i+1] = brw[i] & ~r_i[i];
  end

  assign is_neg = r_i[MSB];
  assign d_o    = is_neg ? {1'b1, ~dec[MSB-1:0]} : r_i;

  always_comb begin
    neg_r = ~r_i + W'(1);
    AST_DISP_POS: assert (is_neg || (d_o == r_i)); // R6
    AST_DISP_NEG: assert (!is_neg || (d_o[MSB] && (d_o[MSB-1:0] == neg_r[MSB-1:0]))); // R7
    AST_DISP_MIN: assert ((r_i != {1'b1, {MSB{1'b0}}}) || (d_o == r_i)); // R8
  end

endmodule

// File: rtl/addsub_unit.sv
module addsub_unit
  import addsub_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] opa_i,
  input  logic [W-1:0] opb_i,
  input  logic         op_sub_i,
  output logic [W-1:0] res_o,
  output logic         cflag_o,
  output logic         ovf_o,
  output logic [W-1:0] disp_o
);

  localparam int MSB = W - 1;

  mode_e mode;
  logic  raw_cout;
  logic  top_cin;
  logic  sa, sb_eff, sr;

  assign mode = mode_e'(op_sub_i);

  addsub_chain #(.W(W)) u_chain (
    .a_i       (opa_i),
    .b_i       (opb_i),
    .mode_i    (op_sub_i),
    .s_o       (res_o),
    .cout_o    (raw_cout),
    .cin_top_o (top_cin)
  );

  addsub_signmag #(.W(W)) u_disp (
    .r_i (res_o),
    .d_o (disp_o)
  );

  assign cflag_o = raw_cout ^ op_sub_i;
  assign ovf_o   = top_cin ^ raw_cout;

  always_comb begin
    sa     = opa_i[MSB];
    sb_eff = opb_i[MSB] ^ op_sub_i;
    sr     = res_o[MSB];
    AST_BORROW: assert ((mode != MODE_SUB) || (cflag_o == (opa_i < opb_i))); // R4
    AST_CARRY: assert ((mode != MODE_ADD) || (cflag_o == (({1'b0, opa_i} + {1'b0, opb_i}) > {1'b0, {W{1'b1}}}))); // R3
    AST_OVERFLOW: assert (ovf_o == ((sa == sb_eff) && (sr != sa))); // R5
  end

endmodule

// File: tb/tb_addsub_unit.sv
module tb_addsub_unit;

  localparam int W = 4;
  localparam int SPAN = 1 << W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] opa, opb, res, disp;
  logic sub, cflag, ovf;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  addsub_unit #(.W(W)) dut (
    .opa_i(opa), .opb_i(opb), .op_sub_i(sub),
    .res_o(res), .cflag_o(cflag), .ovf_o(ovf), .disp_o(disp)
  );

  function automatic int sval(input int u);
    return (u >= SPAN/2) ? u - SPAN : u;
  endfunction

  function automatic int exp_res(input int a, input int b, input int s);
    return s ? ((a - b + SPAN) % SPAN) : ((a + b) % SPAN);
  endfunction

  function automatic int exp_cf(input int a, input int b, input int s);
    return s ? int'(a < b) : int'(a + b >= SPAN);
  endfunction

  function automatic int exp_ovf(input int a, input int b, input int s);
    int t;
    t = s ? sval(a) - sval(b) : sval(a) + sval(b);
    return int'(t < -SPAN/2 || t > SPAN/2 - 1);
  endfunction

  function automatic int exp_disp(input int r);
    int m;
    if (r < SPAN/2) return r;
    m = SPAN - r;
    return SPAN/2 + (m % (SPAN/2));
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d (a=%0d b=%0d sub=%0d)", req, got, exp, opa, opb, sub);
    end
  endtask

  task automatic apply(input int a, input int b, input int s);
    int r;
    @(posedge clk);
    opa = W'(a); opb = W'(b); sub = s[0];
    @(negedge clk);
    r = exp_res(a, b, s);
    check(s ? "R2" : "R1", int'(res), r);
    check(s ? "R4" : "R3", int'(cflag), exp_cf(a, b, s));
    check("R5", int'(ovf), exp_ovf(a, b, s));
    check((r < SPAN/2) ? "R6" : "R7", int'(disp), exp_disp(r));
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    opa = '0; opb = '0; sub = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'(res), 0);
    check("R6", int'(disp), 0);

    // exhaustive sweep of both modes
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < SPAN; a++)
        for (int b = 0; b < SPAN; b++)
          apply(a, b, s);

    // directed corners: most negative value (R8)
    apply(0, 8, 1);
    check("R8", int'(disp), SPAN/2);
    check("R5", int'(ovf), 1);
    apply(8, 0, 0);
    check("R8", int'(disp), SPAN/2);
    apply(8, 1, 1);
    check("R5", int'(ovf), 1);
    apply(15, 1, 0);
    check("R3", int'(cflag), 1);
    apply(3, 3, 1);
    check("R4", int'(cflag), 0);
    apply(2, 3, 1);
    check("R7", int'(disp), 9);

    // random pairs with a fixed seed
    void'($urandom(32'd1234));
    for (int k = 0; k < 200; k++)
      apply(int'($urandom % SPAN), int'($urandom % SPAN), int'($urandom % 2));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule